// File: doc/BRIEF.md
# PTP Fine-Correction Time Counter

This block keeps a precision-time-protocol clock as a seconds count and a nanoseconds count, advanced from a free-running reference clock by fine adjustment. A 32-bit accumulator adds a programmable addend on every reference cycle. On each cycle where that sum wraps past the accumulator's top, the nanoseconds count steps forward by a programmable sub-second increment. The addend therefore sets the clock rate with very fine resolution, while the increment sets the size of each step.

Software sizes the increment to twice the reference period in nanoseconds. The nominal addend is 2^32 · (1e9 / increment) / f_ref, which lands near 2^31, so the accumulator carries about once every two cycles. A fixed 20 ns step works only for reference clocks at 50 MHz or above. With a sized increment, slower reference clocks also give a correct rate. Two register-style write ports load the addend and the increment. When the nanoseconds count reaches its rollover limit, it folds back and a second is added in the same cycle.

Top module: `ptp_fine_clock`

## Requirements
- R1: On every cycle out of reset, the accumulator takes the value accumulator + addend modulo 2^32. A carry is flagged on exactly the cycles where that addition wraps.
- R2: The nanoseconds and seconds outputs change only on carry cycles. With an addend of 0 they never move.
- R3: On each carry, the nanoseconds output grows by the value of the 8-bit increment register, read as nanoseconds. An increment of 0 leaves the time unchanged.
- R4: Starting from a cleared accumulator, an addend of 0x8000_0000 carries on the second cycle and on every second cycle after it. An addend of 0xFFFF_FFFF carries on every cycle from the second. An addend of 0x4000_0000 carries on every fourth cycle.
- R5: The rollover limit is parameter NS_LIMIT, 1,000,000,000 by default. When nanoseconds + increment reaches the limit or more, the nanoseconds output becomes that sum minus the limit and the seconds output rises by one, both in the same cycle. The nanoseconds output therefore always stays below the limit.
- R6: The seconds output is SEC_W bits wide (32 by default) and wraps from its maximum to zero.
- R7: A synchronous active-high reset clears the accumulator, the nanoseconds and seconds counts, and the addend and increment registers.
- R8: A value written on a clock edge is first used on the following cycle: a carry on the write edge still adds the old increment. A write leaves the accumulator contents untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| addendWe | input | 1 | Load strobe for the addend register |
| addendIn | input | ACC_W (32) | New addend value |
| incrWe | input | 1 | Load strobe for the sub-second increment register |
| incrIn | input | 8 | New increment value in nanoseconds |
| nsOut | output | NS_W (30) | Current nanoseconds count |
| secOut | output | SEC_W (32) | Current seconds count |

## Verification
The hardest states to reach from the ports are the nanoseconds rollover and the wrap of the seconds field. With a step of at most 255 ns, a default-sized clock needs millions of cycles to reach one second, and many times that to wrap the seconds. The bench therefore builds the block with a rollover limit of 1000 and a 3-bit seconds field. It then drives an all-ones addend, so the block carries on every cycle, and uses increments of 250 and 255. This lands the rollover both exactly on the limit and past it, and reaches the seconds wrap within a few dozen cycles. The timing of a write is pinned down by changing the increment on an edge that also carries. A second test changes the addend while the accumulator sits at mid-range, which shows the accumulator keeps its contents across a write.

// File: rtl/ptp_fine_pkg.sv
package ptp_fine_pkg;
  // Width of the sub-second increment register, fixed by the block's architecture.
  localparam int PTP_INC_W = 8;

  // Strobes from the rate control to the time datapath.
  typedef struct packed {
    logic                 advance;  // accumulator carried this cycle
    logic [PTP_INC_W-1:0] step;     // nanoseconds to add on advance
  } ptpTick_t;
endpackage

// File: rtl/ptp_fine_ctrl.sv
module ptp_fine_ctrl
  import ptp_fine_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 addendWe,
  input  logic [ACC_W-1:0]     addendIn,
  input  logic                 incrWe,
  input  logic [PTP_INC_W-1:0] incrIn,
  output ptpTick_t             tick,
  output logic [ACC_W-1:0]     accVal
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0]     addendReg;
  logic [PTP_INC_W-1:0] incrReg;
  logic [ACC_W-1:0]     accReg;
  logic [SUM_W-1:0]     accSum;

  // Widened add: the top bit is the carry-out that paces the clock.
  assign accSum = {1'b0, accReg} + {1'b0, addendReg};

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg    <= '0;
      addendReg <= '0;
      incrReg   <= '0;
    end else begin
      accReg <= accSum[ACC_W-1:0];
      if (addendWe) addendReg <= addendIn;
      if (incrWe)   incrReg   <= incrIn;
    end
  end

  assign tick.advance = accSum[SUM_W-1];
  assign tick.step    = incrReg;
  assign accVal       = accReg;
endmodule

// File: rtl/ptp_fine_dp.sv
module ptp_fine_dp
  import ptp_fine_pkg::*;
#(
  parameter int NS_W     = 30,
  parameter int SEC_W    = 32,
  parameter int NS_LIMIT = 1000000000
) (
  input  logic             clk,
  input  logic             rst,
  input  ptpTick_t         tick,
  output logic [NS_W-1:0]  nsOut,
  output logic [SEC_W-1:0] secOut
);
  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] LIMIT_V = SUM_W'(NS_LIMIT);

  logic [NS_W-1:0]  nsReg;
  logic [SEC_W-1:0] secReg;
  logic [SUM_W-1:0] nsSum;
  logic [SUM_W-1:0] nsFolded;
  logic             rollOver;

  assign nsSum    = {1'b0, nsReg} + SUM_W'(tick.step);
  assign rollOver = (nsSum >= LIMIT_V);
  assign nsFolded = nsSum - LIMIT_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      nsReg  <= '0;
      secReg <= '0;
    end else if (tick.advance) begin
      if (rollOver) begin
        nsReg  <= nsFolded[NS_W-1:0];
        secReg <= secReg + SEC_W'(1);
      end else begin
        nsReg  <= nsSum[NS_W-1:0];
      end
    end
  end

  assign nsOut  = nsReg;
  assign secOut = secReg;
endmodule

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock
  import ptp_fine_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int NS_W     = 30,
  parameter int SEC_W    = 32,
  parameter int NS_LIMIT = 1000000000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 addendWe,
  input  logic [ACC_W-1:0]     addendIn,
  input  logic                 incrWe,
  input  logic [PTP_INC_W-1:0] incrIn,
  output logic [NS_W-1:0]      nsOut,
  output logic [SEC_W-1:0]     secOut
);
  ptpTick_t         tickStb;
  logic [ACC_W-1:0] accState;

  ptp_fine_ctrl #(.ACC_W(ACC_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .addendWe (addendWe),
    .addendIn (addendIn),
    .incrWe   (incrWe),
    .incrIn   (incrIn),
    .tick     (tickStb),
    .accVal   (accState)
  );

  ptp_fine_dp #(.NS_W(NS_W), .SEC_W(SEC_W), .NS_LIMIT(NS_LIMIT)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .tick   (tickStb),
    .nsOut  (nsOut),
    .secOut (secOut)
  );
endmodule

// File: rtl/ptp_fine_clock_chk.sv
module ptp_fine_clock_chk
  import ptp_fine_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int NS_W     = 30,
  parameter int SEC_W    = 32,
  parameter int NS_LIMIT = 1000000000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 advance,
  input logic [PTP_INC_W-1:0] step,
  input logic [ACC_W-1:0]     accVal,
  input logic [NS_W-1:0]      nsOut,
  input logic [SEC_W-1:0]     secOut
);
  localparam logic [NS_W:0] LIM = (NS_W+1)'(NS_LIMIT);

  // R1: the accumulator drops below its previous value exactly when a carry was flagged.
  p_acc_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (accVal < $past(accVal)) == $past(advance));

  // R2: no carry, no movement of the time outputs.
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> ($stable(nsOut) && $stable(secOut)));

  // R3 and R5: a carry adds the step, folding at the limit with a second carried.
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    advance |=>
      (({1'b0, nsOut} == {1'b0, $past(nsOut)} + (NS_W+1)'($past(step))) &&
        secOut == $past(secOut)) ||
      (({1'b0, nsOut} + LIM == {1'b0, $past(nsOut)} + (NS_W+1)'($past(step))) &&
        secOut == $past(secOut) + SEC_W'(1)));

  // R5: nanoseconds never reach the rollover limit.
  p_ns_range_r5: assert property (@(posedge clk) disable iff (rst)
    {1'b0, nsOut} < LIM);

  // R6: seconds move only on a carry cycle.
  p_sec_move_r6: assert property (@(posedge clk) disable iff (rst)
    (secOut != $past(secOut)) |-> $past(advance));

  // R7: a reset edge leaves the time cleared.
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (nsOut == '0 && secOut == '0 && accVal == '0));
endmodule

bind ptp_fine_clock ptp_fine_clock_chk #(
  .ACC_W(ACC_W), .NS_W(NS_W), .SEC_W(SEC_W), .NS_LIMIT(NS_LIMIT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .advance (tickStb.advance),
  .step    (tickStb.step),
  .accVal  (accState),
  .nsOut   (nsOut),
  .secOut  (secOut)
);

// File: tb/ptp_fine_clock_tb.sv
`timescale 1ns/1ps
module ptp_fine_clock_tb;
  localparam int ACC_W = 32;
  localparam int NS_W  = 30;
  localparam int SEC_W = 3;
  localparam int LIMIT = 1000;
  localparam int NVEC  = 6;

  // Table: addend, increment, cycles after the write edge, expected nanoseconds.
  localparam logic [31:0] V_ADD [NVEC] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h4000_0000,
                                           32'h0000_0000, 32'h8000_0000, 32'h5555_5556};
  localparam logic [7:0]  V_INC [NVEC] = '{8'd40, 8'd5, 8'd80, 8'd20, 8'd0, 8'd30};
  localparam int          V_CYC [NVEC] = '{10, 8, 12, 6, 10, 9};
  localparam int          V_NS  [NVEC] = '{200, 35, 240, 0, 0, 90};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             addendWe = 1'b0;
  logic [ACC_W-1:0] addendIn = '0;
  logic             incrWe = 1'b0;
  logic [7:0]       incrIn = '0;
  logic [NS_W-1:0]  nsOut;
  logic [SEC_W-1:0] secOut;

  int  compared = 0;
  int  mismatched = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  ptp_fine_clock #(.ACC_W(ACC_W), .NS_W(NS_W), .SEC_W(SEC_W), .NS_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst(rst), .addendWe(addendWe), .addendIn(addendIn),
    .incrWe(incrWe), .incrIn(incrIn), .nsOut(nsOut), .secOut(secOut)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeBoth(input logic [31:0] a, input logic [7:0] i);
    addendWe = 1'b1; addendIn = a; incrWe = 1'b1; incrIn = i;
    @(negedge clk);
    addendWe = 1'b0; incrWe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();
    // R7: reset state
    check("R7", "ns after reset", nsOut, 0);
    check("R7", "sec after reset", secOut, 0);

    // R1 R2 R3 R4: carry rate and step size over several addends
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      writeBoth(V_ADD[v], V_INC[v]);
      repeat (V_CYC[v]) @(negedge clk);
      check("R1/R2/R3/R4", $sformatf("vector %0d ns", v), nsOut, V_NS[v]);
      check("R2", $sformatf("vector %0d sec", v), secOut, 0);
    end

    // R5: rollover landing exactly on the limit
    doReset();
    writeBoth(32'hFFFF_FFFF, 8'd250);
    repeat (5) @(negedge clk);
    check("R5", "exact fold ns", nsOut, 0);
    check("R5", "exact fold sec", secOut, 1);

    // R5: rollover overshooting the limit
    doReset();
    writeBoth(32'hFFFF_FFFF, 8'd255);
    repeat (5) @(negedge clk);
    check("R5", "overshoot ns", nsOut, 20);
    check("R5", "overshoot sec", secOut, 1);

    // R6: seconds wrap to zero
    doReset();
    writeBoth(32'hFFFF_FFFF, 8'd250);
    repeat (29) @(negedge clk);
    check("R6", "sec at max", secOut, 7);
    repeat (4) @(negedge clk);
    check("R6", "sec wrapped", secOut, 0);
    check("R6", "ns at wrap", nsOut, 0);

    // R8: increment written on a carrying edge applies from the next cycle
    doReset();
    writeBoth(32'hFFFF_FFFF, 8'd10);
    repeat (2) @(negedge clk);
    incrWe = 1'b1; incrIn = 8'd100;
    @(negedge clk);
    incrWe = 1'b0;
    @(negedge clk);
    check("R8", "increment write timing", nsOut, 120);

    // R8: addend write keeps the accumulator at mid-range
    doReset();
    writeBoth(32'h8000_0000, 8'd10);
    addendWe = 1'b1; addendIn = 32'h8000_0001;
    @(negedge clk);
    addendWe = 1'b0;
    @(negedge clk);
    check("R8", "accumulator kept across write", nsOut, 10);

    // R7: reset mid-run clears accumulator and registers
    doReset();
    writeBoth(32'h8000_0000, 8'd40);
    repeat (3) @(negedge clk);
    doReset();
    check("R7", "ns after mid-run reset", nsOut, 0);
    check("R7", "sec after mid-run reset", secOut, 0);
    @(negedge clk);
    check("R7", "addend cleared, ns still", nsOut, 0);
    writeBoth(32'h8000_0000, 8'd40);
    @(negedge clk);
    check("R7", "accumulator cleared, no early carry", nsOut, 0);
    @(negedge clk);
    check("R7", "first carry after reset", nsOut, 40);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule